// File: doc/BRIEF.md
# Proportional Two-List Slot Interleaver

This block merges two ordered lists of slot owner IDs into a single schedule. The entries of the shorter list are spread evenly through the longer one. Each list sits in its own small internal store. Software writes the stores one entry at a time; a store entry holding `16'hFFFF` counts as empty. A `start` pulse triggers one merge. The block then streams the merged sequence out on a valid/ready port, one entry per accepted beat. At the end it pulses `done` together with the number of entries it emitted, or it pulses `err`.

Spreading uses a signed credit register. Each round begins with one entry taken from the short list, which adds a fixed step of 100000 to the credit. Long-list entries then follow while credit remains positive, and each one subtracts a target score. The target score is 100000 × (short count) / (long count), using integer division, and is computed once per merge by a serial divider.

Back-pressure rules for the output: once `out_valid` is high, it stays high and `out_id` stays unchanged until `out_ready` is sampled high at a rising edge. An entry is consumed only on a cycle where both are high. `out_valid` never depends on `out_ready`. The lists should not be rewritten while a merge runs; writes that arrive then are dropped.

Top module: `slot_interleave`

## Requirements
- R1: After reset, `out_valid`, `done` and `err` are low, `emit_count` is 0, and every entry of both lists is empty.
- R2: The list holding more non-empty entries is the long list. On a tie, list A (written with `wr_list`=0) is the long list and list B (`wr_list`=1) is the short list.
- R3: Each round emits one short-list entry first, if one remains, and adds 100000 to a 32-bit signed credit that is cleared at start. It then emits long-list entries while one remains and the credit is above zero. Each long-list entry subtracts floor(100000 × short count / long count) from the credit.
- R4: An entry equal to `16'hFFFF` is empty and never emitted. Within each list, entries are emitted in ascending index order.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_id` is stable. Each beat with both high consumes exactly one entry.
- R6: When both lists are exhausted, `done` pulses for one cycle, after the last accepted beat, and `emit_count` then equals the number of beats accepted in this merge.
- R7: If a round would emit nothing while entries remain, `err` pulses for one cycle and the merge stops. This happens when the short list is empty and the long list is not. In that case no entry is emitted.
- R8: If the two lists together hold more than 64 non-empty entries, `err` pulses and no entry is emitted. A merge of exactly 64 entries completes normally.
- R9: A `start` pulse that arrives while a merge is running is ignored: it causes no second merge and no second `done`.
- R10: When both lists are empty, a merge ends with a `done` pulse, `emit_count` of 0 and no beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one list entry (honoured only while idle) |
| wr_list | input | 1 | List select: 0 = list A, 1 = list B |
| wr_addr | input | 6 | Entry index within the selected list |
| wr_data | input | 16 | Owner ID; `16'hFFFF` marks the entry empty |
| start | input | 1 | Pulse to begin a merge |
| out_valid | output | 1 | Merged entry available |
| out_ready | input | 1 | Sink accepts the entry this cycle |
| out_id | output | 16 | Merged owner ID |
| done | output | 1 | One-cycle pulse: merge finished |
| err | output | 1 | One-cycle pulse: merge aborted |
| emit_count | output | 7 | Entries emitted by the current or last merge |

## Verification
Most wrong internal states show up in the order of the output stream. A credit that is updated wrongly, a target score that is off, or a swapped list role changes which list supplies the next beat. That change is visible within one or two beats of the faulty round. A consumption mask that is not cleared either repeats an ID on the next beat or never lets the merge finish. A count or state machine fault shows up at the end of the merge as a missing, doubled or early `done`/`err` pulse, or as an `emit_count` that does not match the beats the sink accepted.

// File: rtl/slot_ilv_pkg.sv
package slot_ilv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_SHORT,
    ST_LONG,
    ST_DONE,
    ST_ERR
  } ilv_state_e;

  localparam logic LIST_A = 1'b0;
  localparam logic LIST_B = 1'b1;
endpackage

// File: rtl/slot_ilv_store.sv
module slot_ilv_store #(
  parameter int DEPTH = 64,
  parameter int ID_W = 16,
  parameter logic [15:0] EMPTY_ID = 16'hFFFF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ID_W-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [ID_W-1:0]  rd_data,
  output logic [DEPTH-1:0] occ
);
  logic [ID_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // occupancy bit per entry: set when a non-empty ID is stored
  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else if (wr_en) occ[wr_addr] <= (wr_data != EMPTY_ID[ID_W-1:0]);
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/slot_ilv_first.sv
module slot_ilv_first #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/slot_ilv_divider.sv
module slot_ilv_divider #(
  parameter int W = 32,
  localparam int LW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  logic [W-1:0]  q;
  logic [W:0]    r;
  logic [LW-1:0] left;
  logic          run;
  logic [W:0]    r_sh;
  logic          ge;

  always_comb begin
    r_sh = {r[W-1:0], q[W-1]};
    ge = (r_sh >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
      r <= '0;
      left <= '0;
      run <= 1'b0;
      done <= 1'b0;
    end else if (start) begin
      q <= num;
      r <= '0;
      left <= LW'(W);
      run <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      r <= ge ? (r_sh - {1'b0, den}) : r_sh;
      q <= {q[W-2:0], ge};
      left <= left - 1'b1;
      if (left == LW'(1)) begin
        run <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign quo = q;
endmodule

// File: rtl/slot_interleave.sv
module slot_interleave #(
  parameter int DEPTH = 64,
  parameter int ID_W = 16,
  parameter logic [15:0] EMPTY_ID = 16'hFFFF,
  parameter int MAX_OUT = 64,
  parameter int STEP = 100000,
  parameter int CREDIT_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LCNT_W = $clog2(DEPTH + 1),
  localparam int TOT_W = LCNT_W + 1,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_list,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [ID_W-1:0]  wr_data,
  input  logic             start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] emit_count
);
  import slot_ilv_pkg::*;

  ilv_state_e state;

  logic [DEPTH-1:0]  occ      [2];
  logic [DEPTH-1:0]  work     [2];
  logic [ID_W-1:0]   rd_data  [2];
  logic [IDX_W-1:0]  head_idx [2];
  logic              head_vld [2];
  logic [LCNT_W-1:0] cnt      [2];

  logic                       long_sel;
  logic                       act;
  logic signed [CREDIT_W-1:0] credit;
  logic [CREDIT_W-1:0]        tgt;
  logic [TOT_W-1:0]           total;
  logic                       over;
  logic                       long_nxt;
  logic                       div_start;
  logic                       div_done;
  logic [CREDIT_W-1:0]        div_q;
  logic [CREDIT_W-1:0]        div_num;
  logic [CREDIT_W-1:0]        div_den;
  logic                       cur_sel;
  logic                       fire;

  for (genvar g = 0; g < 2; g++) begin : g_list
    slot_ilv_store #(
      .DEPTH(DEPTH), .ID_W(ID_W), .EMPTY_ID(EMPTY_ID)
    ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && (wr_list == g[0]) && (state == ST_IDLE)),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (head_idx[g]),
      .rd_data (rd_data[g]),
      .occ     (occ[g])
    );

    slot_ilv_first #(.N(DEPTH)) u_first (
      .vec   (work[g]),
      .found (head_vld[g]),
      .idx   (head_idx[g])
    );

    assign cnt[g] = LCNT_W'($countones(occ[g]));
  end

  // role selection and divider operands, evaluated at start
  always_comb begin
    total = TOT_W'(cnt[0]) + TOT_W'(cnt[1]);
    over = (total > TOT_W'(MAX_OUT));
    long_nxt = (cnt[0] >= cnt[1]) ? LIST_A : LIST_B;
    div_num = CREDIT_W'(STEP) * CREDIT_W'(long_nxt == LIST_A ? cnt[1] : cnt[0]);
    div_den = CREDIT_W'(long_nxt == LIST_A ? cnt[0] : cnt[1]);
    div_start = start && (state == ST_IDLE) && !over;
  end

  slot_ilv_divider #(.W(CREDIT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_q)
  );

  always_comb begin
    cur_sel = (state == ST_LONG) ? long_sel : ~long_sel;
    out_valid = ((state == ST_SHORT) && head_vld[~long_sel]) ||
                ((state == ST_LONG) && head_vld[long_sel] && (credit > 0));
    out_id = rd_data[cur_sel];
    fire = out_valid && out_ready;
    done = (state == ST_DONE);
    err = (state == ST_ERR);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      work[0] <= '0;
      work[1] <= '0;
      long_sel <= LIST_A;
      act <= 1'b0;
      credit <= '0;
      tgt <= '0;
      emit_count <= '0;
    end else begin
      if (fire) begin
        work[cur_sel][head_idx[cur_sel]] <= 1'b0;
        emit_count <= emit_count + 1'b1;
      end
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            work[0] <= occ[0];
            work[1] <= occ[1];
            long_sel <= long_nxt;
            credit <= '0;
            emit_count <= '0;
            state <= over ? ST_ERR : ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_done) begin
            tgt <= div_q;
            state <= ST_SHORT;
          end
        end
        ST_SHORT: begin
          if (!head_vld[0] && !head_vld[1]) begin
            state <= ST_DONE;
          end else if (head_vld[~long_sel]) begin
            if (fire) begin
              credit <= credit + $signed(CREDIT_W'(STEP));
              act <= 1'b1;
              state <= ST_LONG;
            end
          end else begin
            act <= 1'b0;
            state <= ST_LONG;
          end
        end
        ST_LONG: begin
          if (out_valid) begin
            if (fire) begin
              credit <= credit - $signed(tgt);
              act <= 1'b1;
            end
          end else begin
            state <= act ? ST_SHORT : ST_ERR;
          end
        end
        ST_DONE: state <= ST_IDLE;
        ST_ERR:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_interleave_checker.sv
module slot_interleave_checker #(
  parameter int ID_W = 16,
  parameter int CNT_W = 7,
  parameter int MAX_OUT = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ID_W-1:0]  out_id,
  input logic             done,
  input logic             err,
  input logic [CNT_W-1:0] emit_count
);
  logic [CNT_W:0] beats;

  always_ff @(posedge clk) begin
    if (!rst_n) beats <= '0;
    else if (done || err) beats <= '0;
    else if (out_valid && out_ready) beats <= beats + 1'b1;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  assert_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, emit_count} == beats));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    beats <= (CNT_W + 1)'(MAX_OUT));
endmodule

bind slot_interleave slot_interleave_checker #(
  .ID_W(ID_W), .CNT_W(CNT_W), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_id     (out_id),
  .done       (done),
  .err        (err),
  .emit_count (emit_count)
);

// File: tb/slot_interleave_bench.sv
module slot_interleave_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_list = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_id;
  logic        done;
  logic        err;
  logic [6:0]  emit_count;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int got [0:127];
  int got_n;
  int exp_ids [0:127];
  bit saw_done;
  bit saw_err;
  int done_pulses;
  int cnt_at_done;

  slot_interleave u_slot_interleave (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_list(wr_list),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .done(done), .err(err), .emit_count(emit_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic wr(input bit lst, input int idx, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_list = lst;
    wr_addr = idx[5:0];
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_lists();
    for (int l = 0; l < 2; l++)
      for (int i = 0; i < 64; i++) wr(l[0], i, 16'hFFFF);
  endtask

  task automatic run_merge(input int rmode, input bit restart);
    got_n = 0;
    saw_done = 0;
    saw_err = 0;
    done_pulses = 0;
    cnt_at_done = -1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !(saw_done || saw_err); cyc++) begin
      out_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      start = (restart && (cyc == 5 || cyc == 40));
      #1;
      if (out_valid && out_ready) begin
        got[got_n] = int'(out_id);
        got_n++;
      end
      if (done) begin
        saw_done = 1;
        done_pulses++;
        cnt_at_done = int'(emit_count);
      end
      if (err) saw_err = 1;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b1;
  endtask

  task automatic cmp_seq(input string tag, input int n);
    check(got_n == n, {tag, " beat count"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      check(got[i] == exp_ids[i], {tag, " entry order"}, got[i], exp_ids[i]);
  endtask

  task automatic t_reset();
    #1;
    check(!out_valid && !done && !err, "R1 outputs quiet after reset", int'(out_valid), 0);
    check(emit_count == 0, "R1 emit_count after reset", int'(emit_count), 0);
  endtask

  task automatic t_tie();
    clear_lists();
    for (int i = 0; i < 3; i++) begin
      wr(0, i, 16'(10 + i));
      wr(1, i, 16'(20 + i));
    end
    exp_ids[0:5] = '{20, 10, 21, 11, 22, 12};
    run_merge(0, 0);
    cmp_seq("R2 tie: list A long", 6);
    check(saw_done && !saw_err, "R6 tie merge done", int'(saw_done), 1);
    check(cnt_at_done == 6, "R6 emit_count at done", cnt_at_done, 6);
  endtask

  task automatic t_ratio(input int rmode, input bit restart, input string tag);
    clear_lists();
    wr(0, 0, 16'd1);
    wr(0, 1, 16'd2);
    for (int i = 0; i < 6; i++) wr(1, i, 16'(30 + i));
    exp_ids[0:7] = '{1, 30, 31, 32, 33, 2, 34, 35};
    run_merge(rmode, restart);
    cmp_seq(tag, 8);
    check(saw_done && done_pulses == 1, {tag, " single done"}, done_pulses, 1);
    check(cnt_at_done == 8, "R6 emit_count ratio", cnt_at_done, 8);
  endtask

  task automatic t_gaps();
    clear_lists();
    wr(0, 5, 16'h0005);
    wr(0, 9, 16'h0009);
    wr(0, 40, 16'h0040);
    wr(0, 20, 16'hFFFF);
    wr(1, 63, 16'h0077);
    exp_ids[0:3] = '{16'h77, 16'h5, 16'h9, 16'h40};
    run_merge(0, 0);
    cmp_seq("R4 sparse lists", 4);
    check(cnt_at_done == 4, "R4 emit_count sparse", cnt_at_done, 4);
  endtask

  task automatic t_restart_quiet();
    bit seen = 0;
    t_ratio(1, 1, "R9 back-pressure with stray start");
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (out_valid || done || err) seen = 1;
    end
    check(!seen, "R9 no merge after ignored start", int'(seen), 0);
  endtask

  task automatic t_short_empty();
    clear_lists();
    wr(0, 0, 16'd1);
    wr(0, 1, 16'd2);
    run_merge(0, 0);
    check(saw_err && !saw_done, "R7 empty short list aborts", int'(saw_err), 1);
    check(got_n == 0, "R7 no entries emitted", got_n, 0);
  endtask

  task automatic t_both_empty();
    clear_lists();
    run_merge(0, 0);
    check(saw_done && !saw_err, "R10 empty merge done", int'(saw_done), 1);
    check(got_n == 0 && cnt_at_done == 0, "R10 zero entries", got_n, 0);
  endtask

  task automatic t_over();
    clear_lists();
    for (int i = 0; i < 64; i++) wr(0, i, 16'(100 + i));
    wr(1, 0, 16'd7);
    run_merge(0, 0);
    check(saw_err && !saw_done, "R8 65 entries rejected", int'(saw_err), 1);
    check(got_n == 0, "R8 nothing emitted on overflow", got_n, 0);
  endtask

  task automatic t_max();
    wr(0, 63, 16'hFFFF);
    exp_ids[0] = 7;
    for (int i = 0; i < 63; i++) exp_ids[i + 1] = 100 + i;
    run_merge(0, 0);
    cmp_seq("R8 R3 exactly 64 entries", 64);
    check(saw_done && cnt_at_done == 64, "R8 emit_count 64", cnt_at_done, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tie();
    t_ratio(0, 0, "R3 R2 list B long, ratio 2:6");
    t_gaps();
    t_restart_quiet();
    t_short_empty();
    t_both_empty();
    t_over();
    t_max();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule